// File: doc/BRIEF.md
# Transmit FIFO Status and Interrupt Register

This block sits beside the transmit path of an Ethernet MAC and turns the occupancy of the transmit FIFO, plus a one-cycle packet-done pulse from the transmitter, into a small set of status flags that software reads through a two-word register port. The flags are:

- room for another word;
- at least half the FIFO free;
- packet complete;
- FIFO empty.

The same status word also carries six external receive-status pins. Each pin passes through a two-stage synchronizer before it reaches the word.

The packet-complete flag is sticky. Software acknowledges it by writing a one to its bit. While it is set, the room and half-free flags read as zero, so a driver that has just been told a packet finished is not also interrupted for FIFO space. Those two flags come back only after the acknowledge. An interrupt output combines the room, half-free and packet-complete flags, each gated by its own enable bit in a control word.

Top module: `txstat_irq`

## Requirements
- R1: While reset is asserted, with the pins low, the status word (address 0) reads 0x010000 and the control word (address 1) reads 0.
- R2: Status bits 23:20 and 9:0 always read 0. Control bits 23:3 always read 0.
- R3: Status bit 19 reads 1 when the FIFO level is below DEPTH and bit 17 is clear. It follows a change of the level one clock later.
- R4: Status bit 18 reads 1 when DEPTH minus the level is at least DEPTH/2 and bit 17 is clear. It follows a change of the level one clock later.
- R5: Status bit 16 reads 1 when the level is 0, one clock after the level changes. Bit 17 does not affect it.
- R6: Status bit 17 becomes 1 on the clock after a pkt_done pulse. It then stays 1 until a write to address 0 with data bit 17 at 1. A write with data bit 17 at 0 leaves it set.
- R7: While status bit 17 is 1, status bits 19 and 18 read 0. After bit 17 clears, they again follow the FIFO level.
- R8: When pkt_done and a clearing write of bit 17 fall in the same cycle, bit 17 is 1 afterwards.
- R9: Status bits 15:10 equal rx_pins[5:0], delayed by two clocks. After only one clock, the field still holds the old value.
- R10: The control word bits 2, 1 and 0 enable status bits 19, 18 and 17 respectively. irq equals the OR, over those three pairs, of the flag ANDed with its enable.
- R11: Writes to address 0 change no status bit other than clearing bit 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | $clog2(DEPTH+1) | Number of occupied transmit FIFO entries |
| pkt_done | input | 1 | One-cycle pulse when a packet finishes transmitting |
| rx_pins | input | 6 | Asynchronous external receive-status pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the status word, 1 selects the control word |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 24 | Read data for the selected word (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the behaviour of the packet-complete flag:

- it is set after a pulse;
- it holds without a clearing write;
- it clears after a write with no competing pulse;
- it masks the room and half-free flags while it is set.

They also check that an interrupt always has a live flag behind it, and that the empty flag tracks the previous FIFO level. Only the bench's sweeps can show the following:

- the exact status word at every FIFO level, with the packet-complete flag both clear and set;
- every enable pattern against every flag combination;
- the two-clock latency of all 64 pin patterns;
- the race between set and clear;
- immunity of the read-only bits to writes.

// File: rtl/txstat_irq.sv
module txstat_irq #(
  parameter int DEPTH = 8,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LVLW-1:0] fifo_level,
  input  logic            pkt_done,
  input  logic [5:0]      rx_pins,
  input  logic            reg_wr,
  input  logic            reg_addr,
  input  logic [23:0]     reg_wdata,
  output logic [23:0]     reg_rdata,
  output logic            irq
);

  localparam int HALF = DEPTH / 2;
  localparam logic [LVLW:0] DEPTH_W = (LVLW+1)'(DEPTH);
  localparam logic [LVLW:0] HALF_W  = (LVLW+1)'(HALF);

  logic [LVLW:0] free_cnt;
  logic          room_q, half_q, empty_q, done_q;
  logic [5:0]    pin_m, pin_s;
  logic [2:0]    en_q;
  logic          clr_done;
  logic [23:0]   stat_word, ctrl_word;
  logic          unused_wd;

  assign free_cnt  = DEPTH_W - {1'b0, fifo_level};
  assign clr_done  = reg_wr & ~reg_addr & reg_wdata[17];
  assign unused_wd = ^{reg_wdata[23:18], reg_wdata[16:3]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      room_q  <= 1'b0;
      half_q  <= 1'b0;
      empty_q <= 1'b1;
      done_q  <= 1'b0;
      pin_m   <= '0;
      pin_s   <= '0;
      en_q    <= '0;
    end else begin
      room_q  <= {1'b0, fifo_level} < DEPTH_W;
      half_q  <= free_cnt >= HALF_W;
      empty_q <= fifo_level == '0;
      done_q  <= pkt_done | (done_q & ~clr_done);
      pin_m   <= rx_pins;
      pin_s   <= pin_m;
      if (reg_wr && reg_addr) en_q <= reg_wdata[2:0];
    end
  end

  assign stat_word = {4'b0, room_q & ~done_q, half_q & ~done_q, done_q, empty_q,
                      pin_s, 10'b0};
  assign ctrl_word = {21'b0, en_q};
  assign reg_rdata = reg_addr ? ctrl_word : stat_word;
  assign irq       = |(stat_word[19:17] & en_q);

endmodule

module txstat_irq_chk #(
  parameter int LVLW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pkt_done,
  input logic            clr_wr,
  input logic [3:0]      flags,
  input logic [LVLW-1:0] fifo_level,
  input logic            irq
);

  assert_done_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> flags[1]);

  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !clr_wr) |=> flags[1]);

  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !pkt_done) |=> !flags[1]);

  assert_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] |-> (flags[3:2] == 2'b00));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |flags[3:1]);

  assert_empty_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flags[0] == ($past(fifo_level) == '0)));

endmodule

bind txstat_irq txstat_irq_chk #(.LVLW(LVLW)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .pkt_done(pkt_done),
  .clr_wr(reg_wr & ~reg_addr & reg_wdata[17]),
  .flags(stat_word[19:16]),
  .fifo_level(fifo_level),
  .irq(irq)
);

// File: tb/txstat_irq_tb.sv
module txstat_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int LVLW = $clog2(DEPTH + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [LVLW-1:0] fifo_level = '0;
  logic            pkt_done = 1'b0;
  logic [5:0]      rx_pins = '0;
  logic            reg_wr = 1'b0;
  logic            reg_addr = 1'b0;
  logic [23:0]     reg_wdata = '0;
  logic [23:0]     reg_rdata;
  logic            irq;

  int errors = 0;
  int checks = 0;
  logic [5:0] pins_now = '0;

  txstat_irq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .pkt_done(pkt_done),
    .rx_pins(rx_pins), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic a, output logic [23:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic a, input logic [23:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_done();
    pkt_done = 1'b1;
    tick();
    pkt_done = 1'b0;
  endtask

  function automatic logic [23:0] exp_stat(input int lvl, input bit dn, input logic [5:0] p);
    logic room, half;
    room = !dn && (lvl < DEPTH);
    half = !dn && ((DEPTH - lvl) >= DEPTH / 2);
    return {4'b0, room, half, dn, (lvl == 0), p, 10'b0};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] v;
    logic [2:0] fl;
    @(negedge clk);
    rd(1'b0, v); chk("R1 status reset", v, 24'h010000);
    rd(1'b1, v); chk("R1 control reset", v, 24'h000000);
    tick();
    rst_n = 1'b1;

    // R3 R4 R5 R2: level sweep, bit17 clear
    for (int l = 0; l <= DEPTH; l++) begin
      fifo_level = LVLW'(l);
      tick();
      rd(1'b0, v); chk("R3 R4 R5 R2 level sweep", v, exp_stat(l, 1'b0, 6'h0));
    end

    // R6 set, R7 masking sweep
    pulse_done();
    for (int l = 0; l <= DEPTH; l++) begin
      fifo_level = LVLW'(l);
      tick();
      rd(1'b0, v); chk("R7 R6 masked sweep", v, exp_stat(l, 1'b1, 6'h0));
    end

    fifo_level = LVLW'(2);
    tick();
    wr(1'b0, 24'hFDFFFF);
    rd(1'b0, v); chk("R6 R11 write zero to bit17", v, exp_stat(2, 1'b1, 6'h0));
    wr(1'b0, 24'h020000);
    rd(1'b0, v); chk("R6 R7 clear restores", v, exp_stat(2, 1'b0, 6'h0));
    wr(1'b0, 24'hFDFFFF);
    rd(1'b0, v); chk("R11 read-only bits", v, exp_stat(2, 1'b0, 6'h0));

    // R8 race
    pkt_done = 1'b1;
    wr(1'b0, 24'h020000);
    pkt_done = 1'b0;
    rd(1'b0, v); chk("R8 set wins", v, exp_stat(2, 1'b1, 6'h0));
    wr(1'b0, 24'h020000);

    // R2 R10 control readback
    wr(1'b1, 24'hFFFFFF);
    rd(1'b1, v); chk("R2 R10 control readback", v, 24'h000007);

    // R10 interrupt sweep
    for (int l = 0; l <= DEPTH; l++) begin
      for (int dn = 0; dn < 2; dn++) begin
        for (int en = 0; en < 8; en++) begin
          fifo_level = LVLW'(l);
          if (dn != 0) pulse_done(); else wr(1'b0, 24'h020000);
          wr(1'b1, 24'(en));
          fl = {dn == 0 && l < DEPTH, dn == 0 && (DEPTH - l) >= DEPTH / 2, dn != 0};
          #1;
          chk("R10 irq", {23'b0, irq}, {23'b0, |(fl & 3'(en))});
        end
      end
    end
    wr(1'b0, 24'h020000);
    wr(1'b1, 24'h0);
    fifo_level = '0;
    tick();

    // R9 pins sweep
    for (int p = 0; p < 64; p++) begin
      logic [5:0] old;
      old = pins_now;
      rx_pins = 6'(p);
      tick();
      rd(1'b0, v); chk("R9 one clock old", {18'b0, v[15:10]}, {18'b0, old});
      tick();
      pins_now = 6'(p);
      rd(1'b0, v); chk("R9 two clocks", v, exp_stat(0, 1'b0, 6'(p)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule